// File: doc/BRIEF.md
# Exception Entry and Return Sequencer

This block is the part of a processor core that performs the hardware side of taking an interrupt and of leaving a service routine. It holds four registers: the interrupt stack pointer, the program counter, the processor status word and the dispatch-table base. When the interrupt controller raises a request, the block runs a fixed sequence. It lowers the stack pointer by one frame. It pushes the program counter and then the status word. It clears the enable, trace-pending and trace bits of the status word. Only then does it take the vector number, turn it into a dispatch-table address and fetch the routine's start address into the program counter. A return command pops both words back and raises the stack pointer by one frame.

Stack traffic uses a data-memory port and the dispatch fetch uses a program-memory read port. Both ports follow the valid/ready rule. The block raises valid and holds address, direction and write data unchanged until ready is sampled high on a clock edge. A read returns its data in the same cycle as ready. The memory may hold ready low for as long as it needs, and the sequencer stalls in that step without limit. Outside a sequence, the core loads the four registers through plain write strobes.

Top module: `exc_seq`

## Requirements
- R1: After reset, busy, vec_ack, dmem_valid and pmem_valid are low, pc_o and psr_o are 0x0000, and isp_o is 0x0100.
- R2: On an accepted request, the stack pointer drops by 4 (two 16-bit words) before any stack write, and isp_o keeps that value after entry.
- R3: The entry pushes exactly two words. First it writes the old program counter at the new stack pointer. Then it writes the status word at the new stack pointer + 2, as it stood before any bit was cleared.
- R4: After both pushes, status bits 9 (global enable), 1 (trace pending) and 2 (trace) are cleared, and every other bit keeps its value.
- R5: The vector number is sampled only after both pushes are complete, in the single cycle in which vec_ack is high. vec_ack pulses once per entry.
- R6: The dispatch fetch address is base + vector × 2 (modulo 2^16). The word read there becomes pc_o, and busy falls on the same edge.
- R7: On a return command, pc_o is read from the stack pointer and psr_o from the stack pointer + 2. After that, the stack pointer rises by 4, and busy then falls.
- R8: busy is high from the edge after the request or return command until its sequence finishes. While busy, requests, return commands and register write strobes have no effect.
- R9: While valid is high and ready is low on either memory port, valid, address, direction and write data stay unchanged. The two ports are never valid together, and the sequencer waits in a step as long as ready stays low.
- R10: If a request and a return command arrive in the same idle cycle, the request wins and an entry is performed.
- R11: While idle, the strobes wr_pc, wr_psr, wr_isp and wr_base each load wr_data into their register on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | 1 | Interrupt request from the controller |
| rtx_cmd | input | 1 | Return-from-exception command |
| vec_num | input | 6 | Vector number from the interrupt controller |
| vec_ack | output | 1 | Pulse: vector number sampled this cycle |
| busy | output | 1 | A sequence is in progress |
| wr_pc | input | 1 | Load program counter from wr_data |
| wr_psr | input | 1 | Load status word from wr_data |
| wr_isp | input | 1 | Load stack pointer from wr_data |
| wr_base | input | 1 | Load dispatch base from wr_data |
| wr_data | input | 16 | Write data for register loads |
| pc_o | output | 16 | Program counter |
| psr_o | output | 16 | Processor status word |
| isp_o | output | 16 | Interrupt stack pointer |
| dmem_valid | output | 1 | Data-memory access request |
| dmem_ready | input | 1 | Data-memory accepts / returns data |
| dmem_we | output | 1 | 1 = write (push), 0 = read (pop) |
| dmem_addr | output | 16 | Byte address of the stack word |
| dmem_wdata | output | 16 | Word to push |
| dmem_rdata | input | 16 | Popped word, valid with dmem_ready |
| pmem_valid | output | 1 | Dispatch-table read request |
| pmem_ready | input | 1 | Program memory returns data |
| pmem_addr | output | 16 | Dispatch entry byte address |
| pmem_rdata | input | 16 | Dispatch entry content, valid with pmem_ready |

## Verification
A wrong step counter or stack pointer shows up at the data-memory port on the first push, because the write address is off by the frame size. The pushed words expose a program counter or status value that was modified too early. If the vector is latched too early, the bench sees a dispatch address built from a stale vector, because the vector input changes value only once the second push has been accepted. A return that pops in the wrong order or forgets the increment leaves pc_o, psr_o or isp_o wrong on the edge at which busy falls. The same applies to a status mask that touches the wrong bits.

// File: rtl/exc_pkg.sv
package exc_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DEC,
    ST_PUSH_PC,
    ST_PUSH_SR,
    ST_CLR,
    ST_VEC,
    ST_DISP,
    ST_POP_PC,
    ST_POP_SR,
    ST_INC
  } seq_st_e;
endpackage

// File: rtl/exc_ctrl.sv
module exc_ctrl
  import exc_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    irq_req,
  input  logic    rtx_cmd,
  input  logic    dmem_ready,
  input  logic    pmem_ready,
  output seq_st_e state
);
  seq_st_e nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE:    if (irq_req) nxt = ST_DEC;
                  else if (rtx_cmd) nxt = ST_POP_PC;
      ST_DEC:     nxt = ST_PUSH_PC;
      ST_PUSH_PC: if (dmem_ready) nxt = ST_PUSH_SR;
      ST_PUSH_SR: if (dmem_ready) nxt = ST_CLR;
      ST_CLR:     nxt = ST_VEC;
      ST_VEC:     nxt = ST_DISP;
      ST_DISP:    if (pmem_ready) nxt = ST_IDLE;
      ST_POP_PC:  if (dmem_ready) nxt = ST_POP_SR;
      ST_POP_SR:  if (dmem_ready) nxt = ST_INC;
      ST_INC:     nxt = ST_IDLE;
      default:    nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nxt;
  end
endmodule

// File: rtl/exc_ctx.sv
module exc_ctx
  import exc_pkg::*;
#(
  parameter int          XLEN    = 16,
  parameter int          VW      = 6,
  parameter int          BIT_I   = 9,
  parameter int          BIT_P   = 1,
  parameter int          BIT_T   = 2,
  parameter logic [XLEN-1:0] PC_RST  = '0,
  parameter logic [XLEN-1:0] PSR_RST = '0,
  parameter logic [XLEN-1:0] ISP_RST = XLEN'(16'h0100)
)(
  input  logic            clk,
  input  logic            rst_n,
  input  seq_st_e         state,
  input  logic [VW-1:0]   vec_num,
  input  logic            wr_pc,
  input  logic            wr_psr,
  input  logic            wr_isp,
  input  logic            wr_base,
  input  logic [XLEN-1:0] wr_data,
  input  logic            dmem_ready,
  input  logic [XLEN-1:0] dmem_rdata,
  input  logic            pmem_ready,
  input  logic [XLEN-1:0] pmem_rdata,
  output logic [XLEN-1:0] pc,
  output logic [XLEN-1:0] psr,
  output logic [XLEN-1:0] isp,
  output logic [XLEN-1:0] disp
);
  localparam int WORD_B  = XLEN / 8;
  localparam int FRAME_B = 2 * WORD_B;
  localparam logic [XLEN-1:0] CLR_MASK =
    (XLEN'(1) << BIT_I) | (XLEN'(1) << BIT_P) | (XLEN'(1) << BIT_T);

  logic [XLEN-1:0] base;
  logic [XLEN-1:0] entry_addr;

  assign entry_addr = base + XLEN'(vec_num) * XLEN'(WORD_B);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc   <= PC_RST;
      psr  <= PSR_RST;
      isp  <= ISP_RST;
      base <= '0;
      disp <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (wr_pc)   pc   <= wr_data;
          if (wr_psr)  psr  <= wr_data;
          if (wr_isp)  isp  <= wr_data;
          if (wr_base) base <= wr_data;
        end
        ST_DEC:    isp  <= isp - XLEN'(FRAME_B);
        ST_CLR:    psr  <= psr & ~CLR_MASK;
        ST_VEC:    disp <= entry_addr;
        ST_DISP:   if (pmem_ready) pc  <= pmem_rdata;
        ST_POP_PC: if (dmem_ready) pc  <= dmem_rdata;
        ST_POP_SR: if (dmem_ready) psr <= dmem_rdata;
        ST_INC:    isp  <= isp + XLEN'(FRAME_B);
        default:   ;
      endcase
    end
  end
endmodule

// File: rtl/exc_port.sv
module exc_port
  import exc_pkg::*;
#(
  parameter int XLEN = 16
)(
  input  seq_st_e         state,
  input  logic [XLEN-1:0] pc,
  input  logic [XLEN-1:0] psr,
  input  logic [XLEN-1:0] isp,
  input  logic [XLEN-1:0] disp,
  output logic            dmem_valid,
  output logic            dmem_we,
  output logic [XLEN-1:0] dmem_addr,
  output logic [XLEN-1:0] dmem_wdata,
  output logic            pmem_valid,
  output logic [XLEN-1:0] pmem_addr
);
  localparam int WORD_B = XLEN / 8;

  logic second;

  always_comb begin
    dmem_valid = 1'b0;
    dmem_we    = 1'b0;
    second     = 1'b0;
    dmem_wdata = pc;
    unique case (state)
      ST_PUSH_PC: begin dmem_valid = 1'b1; dmem_we = 1'b1; end
      ST_PUSH_SR: begin dmem_valid = 1'b1; dmem_we = 1'b1; second = 1'b1; dmem_wdata = psr; end
      ST_POP_PC:  dmem_valid = 1'b1;
      ST_POP_SR:  begin dmem_valid = 1'b1; second = 1'b1; end
      default:    ;
    endcase
    dmem_addr = second ? isp + XLEN'(WORD_B) : isp;
  end

  assign pmem_valid = (state == ST_DISP);
  assign pmem_addr  = disp;
endmodule

// File: rtl/exc_seq.sv
module exc_seq
  import exc_pkg::*;
#(
  parameter int XLEN = 16,
  parameter int VW   = 6
)(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            irq_req,
  input  logic            rtx_cmd,
  input  logic [VW-1:0]   vec_num,
  output logic            vec_ack,
  output logic            busy,
  input  logic            wr_pc,
  input  logic            wr_psr,
  input  logic            wr_isp,
  input  logic            wr_base,
  input  logic [XLEN-1:0] wr_data,
  output logic [XLEN-1:0] pc_o,
  output logic [XLEN-1:0] psr_o,
  output logic [XLEN-1:0] isp_o,
  output logic            dmem_valid,
  input  logic            dmem_ready,
  output logic            dmem_we,
  output logic [XLEN-1:0] dmem_addr,
  output logic [XLEN-1:0] dmem_wdata,
  input  logic [XLEN-1:0] dmem_rdata,
  output logic            pmem_valid,
  input  logic            pmem_ready,
  output logic [XLEN-1:0] pmem_addr,
  input  logic [XLEN-1:0] pmem_rdata
);
  seq_st_e         state;
  logic [XLEN-1:0] disp;

  exc_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .rtx_cmd(rtx_cmd),
    .dmem_ready(dmem_ready), .pmem_ready(pmem_ready), .state(state)
  );

  exc_ctx #(.XLEN(XLEN), .VW(VW)) u_ctx (
    .clk(clk), .rst_n(rst_n), .state(state), .vec_num(vec_num),
    .wr_pc(wr_pc), .wr_psr(wr_psr), .wr_isp(wr_isp), .wr_base(wr_base),
    .wr_data(wr_data), .dmem_ready(dmem_ready), .dmem_rdata(dmem_rdata),
    .pmem_ready(pmem_ready), .pmem_rdata(pmem_rdata),
    .pc(pc_o), .psr(psr_o), .isp(isp_o), .disp(disp)
  );

  exc_port #(.XLEN(XLEN)) u_port (
    .state(state), .pc(pc_o), .psr(psr_o), .isp(isp_o), .disp(disp),
    .dmem_valid(dmem_valid), .dmem_we(dmem_we), .dmem_addr(dmem_addr),
    .dmem_wdata(dmem_wdata), .pmem_valid(pmem_valid), .pmem_addr(pmem_addr)
  );

  assign busy    = (state != ST_IDLE);
  assign vec_ack = (state == ST_VEC);
endmodule

// File: rtl/exc_seq_chk.sv
module exc_seq_chk #(
  parameter int XLEN = 16
)(
  input logic            clk,
  input logic            rst_n,
  input logic            vec_ack,
  input logic            busy,
  input logic [XLEN-1:0] psr_o,
  input logic [XLEN-1:0] isp_o,
  input logic [XLEN-1:0] pc_o,
  input logic            dmem_valid,
  input logic            dmem_ready,
  input logic            dmem_we,
  input logic [XLEN-1:0] dmem_addr,
  input logic [XLEN-1:0] dmem_wdata,
  input logic [XLEN-1:0] dmem_rdata,
  input logic            pmem_valid,
  input logic            pmem_ready,
  input logic [XLEN-1:0] pmem_addr,
  input logic [XLEN-1:0] pmem_rdata
);
  // R9
  dmem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dmem_valid && !dmem_ready |=> dmem_valid && $stable(dmem_addr)
      && $stable(dmem_we) && $stable(dmem_wdata));

  // R9
  pmem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pmem_valid && !pmem_ready |=> pmem_valid && $stable(pmem_addr));

  // R8
  mem_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dmem_valid || pmem_valid) |-> busy && !(dmem_valid && pmem_valid));

  // R5
  ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vec_ack |=> !vec_ack);

  // R5
  ack_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vec_ack |-> busy && !dmem_valid && !pmem_valid);

  // R4
  bits_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vec_ack |-> !psr_o[9] && !psr_o[1] && !psr_o[2]);

  // R6
  pc_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pmem_valid && pmem_ready |=> !busy && pc_o == $past(pmem_rdata));

  // R2
  push_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dmem_valid && dmem_we |-> dmem_addr == isp_o
      || dmem_addr == isp_o + XLEN'(XLEN / 8));

  // R7
  pop_sr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dmem_valid && !dmem_we && dmem_ready && dmem_addr != isp_o
      |=> psr_o == $past(dmem_rdata));
endmodule

bind exc_seq exc_seq_chk #(.XLEN(XLEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .vec_ack(vec_ack), .busy(busy),
  .psr_o(psr_o), .isp_o(isp_o), .pc_o(pc_o),
  .dmem_valid(dmem_valid), .dmem_ready(dmem_ready), .dmem_we(dmem_we),
  .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata), .dmem_rdata(dmem_rdata),
  .pmem_valid(pmem_valid), .pmem_ready(pmem_ready), .pmem_addr(pmem_addr),
  .pmem_rdata(pmem_rdata)
);

// File: tb/tb_exc_seq.sv
module tb_exc_seq;
  logic clk = 0;
  logic rst_n = 0;
  always #2 clk = ~clk;

  logic irq_req = 0, rtx_cmd = 0;
  logic [5:0] vec_num;
  logic vec_ack, busy;
  logic wr_pc = 0, wr_psr = 0, wr_isp = 0, wr_base = 0;
  logic [15:0] wr_data = 0;
  logic [15:0] pc_o, psr_o, isp_o;
  logic dmem_valid, dmem_we, pmem_valid;
  logic dmem_ready = 0, pmem_ready = 0;
  logic [15:0] dmem_addr, dmem_wdata, pmem_addr;
  logic [15:0] dmem_rdata = 0, pmem_rdata = 0;

  exc_seq dut (.*);

  int checks = 0, errors = 0;
  int dlat = 0, dwait = 0, pwait = 0;
  int wr_cnt = 0, seq_start = 0, ack_cnt = 0;
  logic [5:0] vec_pre = 0, vec_post = 0;
  logic [15:0] mem [64];
  logic [15:0] wl_addr [2];
  logic [15:0] wl_data [2];
  logic [15:0] last_paddr = 0;

  localparam logic [15:0] CLR = 16'h0206;

  function automatic logic [15:0] ptab(input logic [15:0] a);
    return a * 16'd3 + 16'h1001;
  endfunction

  assign vec_num = (wr_cnt - seq_start >= 2) ? vec_post : vec_pre;

  // memory models, evaluated away from the active edge
  always @(negedge clk) begin
    if (!rst_n) begin
      dmem_ready = 0; pmem_ready = 0; dwait = 0; pwait = 0;
    end else begin
      if (dmem_ready) begin dmem_ready = 0; dwait = 0; end
      else if (dmem_valid) begin
        if (dwait >= dlat) begin
          dmem_ready = 1;
          if (dmem_we) begin
            mem[dmem_addr[6:1]] = dmem_wdata;
            if (wr_cnt - seq_start < 2) begin
              wl_addr[wr_cnt - seq_start] = dmem_addr;
              wl_data[wr_cnt - seq_start] = dmem_wdata;
            end
            wr_cnt++;
          end else dmem_rdata = mem[dmem_addr[6:1]];
        end else dwait++;
      end
      if (pmem_ready) begin pmem_ready = 0; pwait = 0; end
      else if (pmem_valid) begin
        if (pwait >= dlat) begin
          pmem_ready = 1; pmem_rdata = ptab(pmem_addr); last_paddr = pmem_addr;
        end else pwait++;
      end
    end
  end

  always @(negedge clk) if (rst_n && vec_ack) ack_cnt++;

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input int sel, input logic [15:0] v);
    @(negedge clk);
    wr_data = v;
    wr_pc = (sel == 0); wr_psr = (sel == 1); wr_isp = (sel == 2); wr_base = (sel == 3);
    @(negedge clk);
    wr_pc = 0; wr_psr = 0; wr_isp = 0; wr_base = 0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 400 && busy; i++) @(negedge clk);
  endtask

  task automatic run_irq(input logic [5:0] v, input logic with_rtx);
    seq_start = wr_cnt;
    vec_pre = ~v; vec_post = v;
    @(negedge clk);
    irq_req = 1; rtx_cmd = with_rtx;
    @(negedge clk);
    irq_req = 0; rtx_cmd = 0;
    chk("R8 busy after request", {15'd0, busy}, 16'd1);
    wait_idle();
  endtask

  task automatic run_rtx();
    @(negedge clk);
    rtx_cmd = 1;
    @(negedge clk);
    rtx_cmd = 0;
    chk("R8 busy after return cmd", {15'd0, busy}, 16'd1);
    wait_idle();
  endtask

  localparam int NROW = 5;
  localparam logic [5:0]  T_VEC [NROW]  = '{6'd1, 6'd21, 6'd37, 6'd0, 6'd63};
  localparam logic [15:0] T_BASE [NROW] = '{16'h0100, 16'h0200, 16'h0FFE, 16'h0000, 16'hFF80};
  localparam logic [15:0] T_ISP [NROW]  = '{16'h0040, 16'h0030, 16'h0020, 16'h0010, 16'h007C};
  localparam logic [15:0] T_PC [NROW]   = '{16'h1234, 16'hBEEF, 16'h0002, 16'h7FFE, 16'h5555};
  localparam logic [15:0] T_PSR [NROW]  = '{16'h0206, 16'hFFFF, 16'h0000, 16'h0A0A, 16'h8004};
  localparam int          T_LAT [NROW]  = '{0, 1, 2, 3, 1};

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 busy", {15'd0, busy}, 16'd0);
    chk("R1 valid", {14'd0, dmem_valid, pmem_valid}, 16'd0);
    chk("R1 pc", pc_o, 16'h0000);
    chk("R1 psr", psr_o, 16'h0000);
    chk("R1 isp", isp_o, 16'h0100);

    for (int r = 0; r < NROW; r++) begin
      logic [15:0] ea;
      int a0;
      wr_reg(0, T_PC[r]); wr_reg(1, T_PSR[r]); wr_reg(2, T_ISP[r]); wr_reg(3, T_BASE[r]);
      chk("R11 pc load", pc_o, T_PC[r]);
      chk("R11 isp load", isp_o, T_ISP[r]);
      dlat = T_LAT[r];
      a0 = ack_cnt;
      run_irq(T_VEC[r], 1'b0);
      ea = T_BASE[r] + {9'd0, T_VEC[r], 1'b0};
      chk("R2 isp after entry", isp_o, T_ISP[r] - 16'd4);
      chk("R3 first push addr", wl_addr[0], T_ISP[r] - 16'd4);
      chk("R3 first push data", wl_data[0], T_PC[r]);
      chk("R3 second push addr", wl_addr[1], T_ISP[r] - 16'd2);
      chk("R3 second push data", wl_data[1], T_PSR[r]);
      chk("R4 psr cleared", psr_o, T_PSR[r] & ~CLR);
      chk("R5 one vec_ack", 16'(ack_cnt - a0), 16'd1);
      chk("R6 dispatch addr", last_paddr, ea);
      chk("R6 new pc", pc_o, ptab(ea));
      run_rtx();
      chk("R7 pc restored", pc_o, T_PC[r]);
      chk("R7 psr restored", psr_o, T_PSR[r]);
      chk("R7 isp restored", isp_o, T_ISP[r]);
    end

    // R10: request and return command together -> entry
    dlat = 1;
    wr_reg(0, 16'h4444); wr_reg(1, 16'h0200); wr_reg(2, 16'h0040); wr_reg(3, 16'h0100);
    run_irq(6'd5, 1'b1);
    chk("R10 entry taken isp", isp_o, 16'h003C);
    chk("R10 entry taken pc", pc_o, ptab(16'h010A));
    run_rtx();
    chk("R10 restore pc", pc_o, 16'h4444);

    // R8: request, return and writes ignored while busy
    begin
      int a0;
      a0 = ack_cnt;
      dlat = 3;
      seq_start = wr_cnt;
      vec_pre = 6'd3; vec_post = 6'd3;
      @(negedge clk); irq_req = 1;
      @(negedge clk); irq_req = 0;
      @(negedge clk); irq_req = 1; wr_pc = 1; wr_isp = 1; wr_data = 16'hDEAD;
      @(negedge clk); irq_req = 0; wr_pc = 0; wr_isp = 0;
      repeat (6) @(negedge clk);
      rtx_cmd = 1; wr_psr = 1;
      @(negedge clk); rtx_cmd = 0; wr_psr = 0;
      wait_idle();
      chk("R8 pc not overwritten", pc_o, ptab(16'h0106));
      chk("R8 isp not overwritten", isp_o, 16'h003C);
      chk("R8 psr not overwritten", psr_o, 16'h0000);
      repeat (3) @(negedge clk);
      chk("R8 no extra sequence", {15'd0, busy}, 16'd0);
      chk("R8 single vec_ack", 16'(ack_cnt - a0), 16'd1);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule